// File: doc/BRIEF.md
# SPI Slave with Semaphore Buffer Handoff

This block is an SPI slave (mode 0, MSB first) that shares a small byte buffer with a host CPU. A three-state hardware semaphore tracks who may safely update that buffer: nobody, the CPU or the SPI side. The semaphore only reports ownership. CPU reads and writes of the buffer are never blocked.

Chip select frames each transfer. When chip select falls, the slave takes the semaphore unless the CPU holds it. When chip select rises, the slave latches how many bytes it received and sent, pulses an end event and frees the semaphore. A CPU acquire request made while chip select is low is held back and granted on the next rising edge of chip select. While the slave owns the semaphore, received bytes go to the buffer starting at a receive offset, and transmitted bytes come from the buffer starting at a transmit offset. Both offsets wrap around the buffer. Each direction has a byte limit. If the CPU owns the semaphore when a transfer starts, the slave sends a default byte on every byte and drops what it receives.

SCK, MOSI and chip select are asynchronous. Each passes through a two-flop synchronizer, so the master must keep SCK low for at least 10 system clocks after chip select falls, and each SCK phase must last at least 5 system clocks.

Top module: `spi_sem_slave`

## Requirements
- R1: After reset, `sem_state_o` is 0 (free), `acquired_o` and `end_o` are low, and both byte amounts are 0. The state encoding is 0 = free, 1 = CPU-owned, 2 = SPI-owned.
- R2: A one-cycle `acq_req_i` while chip select is high and the CPU does not own the semaphore sets the state to 1 in the next cycle, and `acquired_o` is high for exactly that one cycle. A `rel_req_i` while the CPU owns the semaphore sets the state to 0.
- R3: A falling chip select while the CPU does not own the semaphore sets the state to 2. The rising chip select that ends that transfer pulses `end_o` for one cycle and leaves the state 0, unless a grant is pending (R4).
- R4: An `acq_req_i` while chip select is low does not change the state and does not pulse `acquired_o`. On the next rising chip select, the state becomes 1 and `acquired_o` pulses in the same cycle as `end_o`.
- R5: If the state is 1 when chip select falls, every byte shifted out is `def_byte_i`, and no received byte is written. At the end of the transfer there is no `end_o` pulse, and the byte amounts keep their old values.
- R6: In an owned transfer, MOSI is sampled on the rising edge of SCK and MISO changes after the falling edge, MSB first. Received byte n is written to buffer address (`rx_ptr_i`+n) mod DEPTH. Transmitted byte n is read from address (`tx_ptr_i`+n) mod DEPTH.
- R7: Received bytes with index n >= `rx_max_i` are dropped. At the end of the transfer, `rx_amount_o` equals min(bytes received, `rx_max_i`).
- R8: Transmitted bytes with index n >= `tx_max_i` are `orc_byte_i`. At the end of the transfer, `tx_amount_o` equals min(bytes clocked, `tx_max_i`).
- R9: CPU writes through `cpu_we_i` and reads through `cpu_rdata_o` take effect in any semaphore state, including while the SPI side owns the semaphore.
- R10: While chip select stays low, the state stays 2 once it is 2, and `rel_req_i` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI clock from the master (mode 0) |
| mosi_i | input | 1 | Serial data from the master |
| csn_i | input | 1 | Chip select, active low |
| miso_o | output | 1 | Serial data to the master |
| acq_req_i | input | 1 | CPU acquire strobe |
| rel_req_i | input | 1 | CPU release strobe |
| acquired_o | output | 1 | One-cycle event: the CPU has been granted the semaphore |
| end_o | output | 1 | One-cycle event: an owned transfer has ended |
| sem_state_o | output | 2 | Semaphore state: 0 free, 1 CPU, 2 SPI |
| rx_ptr_i | input | AW | Buffer offset for received bytes |
| tx_ptr_i | input | AW | Buffer offset for transmitted bytes |
| rx_max_i | input | CNT_W | Receive byte limit |
| tx_max_i | input | CNT_W | Transmit byte limit |
| def_byte_i | input | 8 | Byte sent when the CPU owns the semaphore |
| orc_byte_i | input | 8 | Byte sent beyond the transmit limit |
| rx_amount_o | output | CNT_W | Bytes stored in the last owned transfer |
| tx_amount_o | output | CNT_W | Bytes sent from the buffer in the last owned transfer |
| cpu_we_i | input | 1 | CPU buffer write enable |
| cpu_addr_i | input | AW | CPU buffer address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data (combinational) |

## Verification
The assertions check the ownership rules on every cycle:
- a grant always leaves the CPU as owner;
- no grant is issued while the synchronized chip select is low;
- an end event always moves the state out of SPI ownership;
- a direct handoff from SPI to CPU is always marked by both events;
- SPI ownership holds for as long as chip select stays low;
- the latched byte amounts never exceed their limits.

Only the bench scenarios can show the data path: which bytes appear on MISO, the buffer addresses and wrap-around, the dropped and over-read bytes, and the default byte in a CPU-owned transfer.

// File: rtl/spi_sem_pkg.sv
package spi_sem_pkg;
  typedef enum logic [1:0] {
    SEM_FREE = 2'd0,
    SEM_CPU  = 2'd1,
    SEM_SPI  = 2'd2
  } sem_e;
endpackage

// File: rtl/spi_sem_sync.sv
module spi_sem_sync #(
  parameter int          N    = 3,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st <= {2{INIT[g]}};
      else         st <= {st[0], d_i[g]};
    end
    assign q_o[g] = st[1];
  end
endmodule

// File: rtl/spi_sem_arbiter.sv
module spi_sem_arbiter
  import spi_sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_low_i,
  input  logic cs_fall_i,
  input  logic cs_rise_i,
  input  logic acq_req_i,
  input  logic rel_req_i,
  output sem_e state_o,
  output logic acquired_o,
  output logic end_o
);
  sem_e state_q, s;
  logic pend_q, p, acq, fin;

  // order: release, transfer end, acquire, transfer start
  always_comb begin
    s   = state_q;
    p   = pend_q;
    acq = 1'b0;
    fin = 1'b0;
    if (rel_req_i && s == SEM_CPU) s = SEM_FREE;
    if (cs_rise_i) begin
      fin = (s == SEM_SPI);
      if (s == SEM_SPI) s = SEM_FREE;
      if (p) begin
        s   = SEM_CPU;
        acq = 1'b1;
        p   = 1'b0;
      end
    end
    if (acq_req_i && s != SEM_CPU) begin
      if (cs_low_i) p = 1'b1;
      else begin
        s   = SEM_CPU;
        acq = 1'b1;
      end
    end
    if (cs_fall_i && s != SEM_CPU) s = SEM_SPI;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEM_FREE;
      pend_q     <= 1'b0;
      acquired_o <= 1'b0;
      end_o      <= 1'b0;
    end else begin
      state_q    <= s;
      pend_q     <= p;
      acquired_o <= acq;
      end_o      <= fin;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/spi_sem_shifter.sv
module spi_sem_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         sck_rise_i,
  input  logic         sck_fall_i,
  input  logic         mosi_i,
  input  logic [W-1:0] load_byte_i,
  output logic         byte_done_o,
  output logic [W-1:0] rx_byte_o,
  output logic         miso_o
);
  localparam int BW = $clog2(W);

  logic [BW-1:0] bit_cnt;
  logic [W-1:0]  rx_sh, tx_sh;
  logic          last_bit;

  assign last_bit    = (bit_cnt == BW'(W - 1));
  assign byte_done_o = sck_rise_i && last_bit;
  assign rx_byte_o   = {rx_sh[W-2:0], mosi_i};
  assign miso_o      = tx_sh[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else if (start_i) begin
      bit_cnt <= '0;
      tx_sh   <= load_byte_i;
    end else begin
      if (sck_rise_i) begin
        rx_sh   <= rx_byte_o;
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
      end
      if (sck_fall_i) begin
        // byte boundary: fetch next byte, else shift MSB first
        if (bit_cnt == '0) tx_sh <= load_byte_i;
        else               tx_sh <= {tx_sh[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_sem_slave.sv
module spi_sem_slave
  import spi_sem_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             mosi_i,
  input  logic             csn_i,
  output logic             miso_o,
  input  logic             acq_req_i,
  input  logic             rel_req_i,
  output logic             acquired_o,
  output logic             end_o,
  output logic [1:0]       sem_state_o,
  input  logic [AW-1:0]    rx_ptr_i,
  input  logic [AW-1:0]    tx_ptr_i,
  input  logic [CNT_W-1:0] rx_max_i,
  input  logic [CNT_W-1:0] tx_max_i,
  input  logic [7:0]       def_byte_i,
  input  logic [7:0]       orc_byte_i,
  output logic [CNT_W-1:0] rx_amount_o,
  output logic [CNT_W-1:0] tx_amount_o,
  input  logic             cpu_we_i,
  input  logic [AW-1:0]    cpu_addr_i,
  input  logic [7:0]       cpu_wdata_i,
  output logic [7:0]       cpu_rdata_o
);
  logic [2:0] sync_q;
  logic       sck_s, mosi_s, cs_s, sck_d, cs_d;
  logic       sck_rise, sck_fall, cs_rise, cs_fall, start_q;
  sem_e       state;
  logic       owned, byte_done, rx_we;
  logic [7:0] rx_byte, tx_byte;
  logic [CNT_W-1:0] byte_cnt;
  logic [AW-1:0]    rx_addr, tx_addr;
  logic [7:0]       mem [DEPTH];

  spi_sem_sync #(.N(3), .INIT(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({csn_i, mosi_i, sck_i}),
    .q_o (sync_q)
  );
  assign {cs_s, mosi_s, sck_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d   <= 1'b0;
      cs_d    <= 1'b1;
      start_q <= 1'b0;
    end else begin
      sck_d   <= sck_s;
      cs_d    <= cs_s;
      start_q <= cs_fall;
    end
  end
  assign sck_rise = sck_s & ~sck_d & ~cs_s;
  assign sck_fall = ~sck_s & sck_d & ~cs_s;
  assign cs_fall  = ~cs_s & cs_d;
  assign cs_rise  = cs_s & ~cs_d;

  spi_sem_arbiter u_arb (
    .clk_i, .rst_ni,
    .cs_low_i   (~cs_s),
    .cs_fall_i  (cs_fall),
    .cs_rise_i  (cs_rise),
    .acq_req_i,
    .rel_req_i,
    .state_o    (state),
    .acquired_o,
    .end_o
  );
  assign sem_state_o = state;
  assign owned       = (state == SEM_SPI);

  spi_sem_shifter #(.W(8)) u_shift (
    .clk_i, .rst_ni,
    .start_i     (start_q),
    .sck_rise_i  (sck_rise),
    .sck_fall_i  (sck_fall),
    .mosi_i      (mosi_s),
    .load_byte_i (tx_byte),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_byte),
    .miso_o
  );

  assign rx_addr = rx_ptr_i + AW'(byte_cnt);
  assign tx_addr = tx_ptr_i + AW'(byte_cnt);
  assign rx_we   = byte_done && owned && (byte_cnt < rx_max_i);

  always_comb begin
    if (!owned)                  tx_byte = def_byte_i;
    else if (byte_cnt < tx_max_i) tx_byte = mem[tx_addr];
    else                         tx_byte = orc_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_cnt    <= '0;
      rx_amount_o <= '0;
      tx_amount_o <= '0;
    end else begin
      if (cs_fall) byte_cnt <= '0;
      else if (byte_done && byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;
      if (cs_rise && owned) begin
        rx_amount_o <= (byte_cnt < rx_max_i) ? byte_cnt : rx_max_i;
        tx_amount_o <= (byte_cnt < tx_max_i) ? byte_cnt : tx_max_i;
      end
    end
  end

  // CPU access is never gated; CPU write wins an address collision
  always_ff @(posedge clk_i) begin
    if (rx_we)    mem[rx_addr]    <= rx_byte;
    if (cpu_we_i) mem[cpu_addr_i] <= cpu_wdata_i;
  end
  assign cpu_rdata_o = mem[cpu_addr_i];
endmodule

// File: rtl/spi_sem_slave_chk.sv
module spi_sem_slave_chk
  import spi_sem_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_s,
  input logic [1:0]       sem_state_o,
  input logic             acquired_o,
  input logic             end_o,
  input logic [CNT_W-1:0] rx_amount_o,
  input logic [CNT_W-1:0] tx_amount_o,
  input logic [CNT_W-1:0] rx_max_i,
  input logic [CNT_W-1:0] tx_max_i
);
  assert_grant_owns_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acquired_o |-> sem_state_o == SEM_CPU);

  assert_no_grant_in_xfer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acquired_o |-> $past(cs_s));

  assert_end_releases_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> ($past(sem_state_o) == SEM_SPI && sem_state_o != SEM_SPI));

  assert_handoff_events_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sem_state_o == SEM_CPU && $past(sem_state_o) == SEM_SPI) |-> (end_o && acquired_o));

  assert_held_while_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_s && !$past(cs_s) && $past(sem_state_o) == SEM_SPI) |-> sem_state_o == SEM_SPI);

  assert_rx_clamp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> rx_amount_o <= rx_max_i);

  assert_tx_clamp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> tx_amount_o <= tx_max_i);
endmodule

bind spi_sem_slave spi_sem_slave_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_s        (cs_s),
  .sem_state_o (sem_state_o),
  .acquired_o  (acquired_o),
  .end_o       (end_o),
  .rx_amount_o (rx_amount_o),
  .tx_amount_o (tx_amount_o),
  .rx_max_i    (rx_max_i),
  .tx_max_i    (tx_max_i)
);

// File: tb/spi_sem_slave_tb_top.sv
module spi_sem_slave_tb_top;
  localparam int DEPTH = 16;
  localparam int CNT_W = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int HALF  = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, csn = 1'b1, miso;
  logic acq_req = 1'b0, rel_req = 1'b0, acquired, end_ev;
  logic [1:0] sem;
  logic [AW-1:0] rx_ptr = '0, tx_ptr = '0, cpu_addr = '0;
  logic [CNT_W-1:0] rx_max = '0, tx_max = '0, rx_amt, tx_amt;
  logic [7:0] def_byte = 8'h99, orc_byte = 8'hEE, cpu_wdata = '0, cpu_rdata;
  logic cpu_we = 1'b0;

  int checks = 0, errors = 0, acq_cnt = 0, end_cnt = 0;
  logic [7:0] exp_q[$], act_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #4 clk = ~clk;

  spi_sem_slave #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni, .sck_i(sck), .mosi_i(mosi), .csn_i(csn), .miso_o(miso),
    .acq_req_i(acq_req), .rel_req_i(rel_req), .acquired_o(acquired), .end_o(end_ev),
    .sem_state_o(sem), .rx_ptr_i(rx_ptr), .tx_ptr_i(tx_ptr), .rx_max_i(rx_max),
    .tx_max_i(tx_max), .def_byte_i(def_byte), .orc_byte_i(orc_byte),
    .rx_amount_o(rx_amt), .tx_amount_o(tx_amt), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata)
  );

  always @(posedge clk) begin
    if (acquired) acq_cnt++;
    if (end_ev)   end_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares master-received bytes against expectations
  always @(negedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      chk(tag_q.pop_front(), {24'd0, act_q.pop_front()}, {24'd0, exp_q.pop_front()});
    end
  end

  task automatic cs_low();
    @(negedge clk) csn = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // driver: one byte in mode 0, pushes expected MISO byte to the scoreboard
  task automatic xfer_byte(input logic [7:0] tx, input logic [7:0] exp, input string tag);
    logic [7:0] rx = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx  = {rx[6:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    act_q.push_back(rx);
  endtask

  task automatic cpu_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = AW'(a); cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cpu_addr = AW'(a);
    #1;
    chk(tag, {24'd0, cpu_rdata}, {24'd0, exp});
  endtask

  task automatic pulse_acq();
    @(negedge clk) acq_req = 1'b1;
    @(negedge clk) acq_req = 1'b0;
  endtask

  task automatic pulse_rel();
    @(negedge clk) rel_req = 1'b1;
    @(negedge clk) rel_req = 1'b0;
  endtask

  initial begin
    int a0, e0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sem", {30'd0, sem}, 0);
    chk("R1 acquired", {31'd0, acquired}, 0);
    chk("R1 end", {31'd0, end_ev}, 0);
    chk("R1 rx_amount", {24'd0, rx_amt}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 tx_amount", {24'd0, tx_amt}, 0);

    for (int i = 0; i < DEPTH; i++) cpu_wr(i, 8'h70 + 8'(i));

    // R2 immediate grant and release
    a0 = acq_cnt;
    @(negedge clk) acq_req = 1'b1;
    @(negedge clk) acq_req = 1'b0;
    chk("R2 acquired pulse", {31'd0, acquired}, 1);
    chk("R2 sem cpu", {30'd0, sem}, 1);
    @(negedge clk);
    chk("R2 acquired one cycle", {31'd0, acquired}, 0);
    pulse_rel();
    chk("R2 sem free after release", {30'd0, sem}, 0);

    // R6 R7 R8 owned transfer with limits
    cpu_wr(8, 8'hA5); cpu_wr(9, 8'h3C); cpu_wr(10, 8'h0F);
    rx_ptr = 0; tx_ptr = 8; rx_max = 2; tx_max = 2;
    e0 = end_cnt;
    cs_low();
    chk("R3 sem spi on cs fall", {30'd0, sem}, 2);
    xfer_byte(8'h11, 8'hA5, "R6 miso byte0");
    xfer_byte(8'h22, 8'h3C, "R6 miso byte1");
    xfer_byte(8'h33, 8'hEE, "R8 over-read byte");
    cs_high();
    chk("R3 end pulse", end_cnt - e0, 1);
    chk("R3 sem free after end", {30'd0, sem}, 0);
    chk("R7 rx_amount clamp", {24'd0, rx_amt}, 2);
    chk("R8 tx_amount clamp", {24'd0, tx_amt}, 2);
    cpu_rd(0, 8'h11, "R6 rx byte0 stored");
    cpu_rd(1, 8'h22, "R6 rx byte1 stored");
    cpu_rd(2, 8'h72, "R7 rx byte beyond max dropped");

    // R6 pointer wrap
    rx_ptr = 15; tx_ptr = 12; rx_max = 4; tx_max = 4;
    cs_low();
    xfer_byte(8'h81, 8'h7C, "R6 wrap miso0");
    xfer_byte(8'h42, 8'h7D, "R6 wrap miso1");
    cs_high();
    cpu_rd(15, 8'h81, "R6 wrap rx at 15");
    cpu_rd(0, 8'h42, "R6 wrap rx at 0");
    chk("R7 rx_amount under max", {24'd0, rx_amt}, 2);

    // R4 deferred grant, R9 CPU access during SPI ownership
    rx_ptr = 4; tx_ptr = 8;
    a0 = acq_cnt; e0 = end_cnt;
    cs_low();
    pulse_acq();
    repeat (3) @(negedge clk);
    chk("R4 no grant while cs low", acq_cnt - a0, 0);
    chk("R4 sem stays spi", {30'd0, sem}, 2);
    cpu_wr(12, 8'h5A);
    cpu_rd(12, 8'h5A, "R9 cpu write during spi ownership");
    xfer_byte(8'hC3, 8'hA5, "R6 miso deferred xfer");
    cs_high();
    chk("R4 grant on cs rise", acq_cnt - a0, 1);
    chk("R4 end on cs rise", end_cnt - e0, 1);
    chk("R4 sem cpu after rise", {30'd0, sem}, 1);
    cpu_rd(4, 8'hC3, "R6 rx stored deferred xfer");

    // R5 CPU-owned transfer
    e0 = end_cnt;
    cs_low();
    chk("R5 sem stays cpu", {30'd0, sem}, 1);
    xfer_byte(8'h55, 8'h99, "R5 default byte0");
    xfer_byte(8'h66, 8'h99, "R5 default byte1");
    cs_high();
    chk("R5 no end", end_cnt - e0, 0);
    chk("R5 rx_amount kept", {24'd0, rx_amt}, 1);
    cpu_rd(4, 8'hC3, "R5 rx discarded 4");
    cpu_rd(5, 8'h75, "R5 rx discarded 5");
    pulse_rel();
    chk("R2 release to free", {30'd0, sem}, 0);

    // R10 chip select held low
    a0 = acq_cnt;
    cs_low();
    pulse_rel();
    repeat (200) @(negedge clk);
    chk("R10 sem held spi", {30'd0, sem}, 2);
    chk("R10 no grant", acq_cnt - a0, 0);
    cs_high();
    chk("R10 free after rise", {30'd0, sem}, 0);

    repeat (4) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule